// File: doc/BRIEF.md
# Complex Transmit Word Deinterleaver

This block sits at the entry of a transmit datapath. Sample words arrive on one shared parallel port. The block turns them into I and Q words in signed two's complement form. In single-channel mode every captured word is a real sample, and it is presented on the I output. In dual (interleaved) mode, words arrive as alternating members of complex pairs. A sync line, read together with a polarity control, marks whether each word opens or closes its pair. A second control decides whether the opening word is I or Q.

The capture point is selectable. It can be the rising edge, the falling edge, or both edges of the clock. Capture on both edges suits a clock that runs at half the interleaved word rate. All control inputs are static: they change only while reset is held. The result leaves as a registered I/Q pair qualified by a one-cycle valid strobe.

Top module: `txq_deinterleave`

## Requirements
- R1: While reset is low at a rising edge, the following edge leaves `out_valid` low and both `i_out` and `q_out` at zero.
- R2: With `cfg_dual` low, every captured word appears on `i_out` with `out_valid` high at the rising edge after its capture, and `q_out` reads zero.
- R3: With `cfg_dual` high and `cfg_q_first` low, the opening word of a pair goes to `i_out` and the closing word to `q_out`, with one `out_valid` pulse per completed pair; between pulses the outputs hold.
- R4: With `cfg_dual` high and `cfg_q_first` high, the opening word goes to `q_out` and the closing word to `i_out`.
- R5: A word opens a pair when its captured `tx_sync` equals `cfg_sync_inv` (sync low opens when the bit is 0, sync high opens when it is 1), otherwise it closes one.
- R6: With `cfg_twos` low, input is offset binary and bit DATA_W-1 is inverted on the way out; with `cfg_twos` high, words pass unchanged.
- R7: With `cfg_fall` high (and two-edge capture not in effect), words are sampled at the falling edge and delivered at the next rising edge.
- R8: With `cfg_dual` and `cfg_both` high, one word is captured at every rising and every falling edge, the rising-edge word counts as earlier than the falling-edge word of the following half cycle, and `cfg_fall` has no effect.
- R9: A closing word with no open pair is discarded without a strobe; an opening word arriving while a pair is already open replaces the held word.
- R10: With `cfg_dual` low, `cfg_both` has no effect and capture follows `cfg_fall` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock; both edges may capture |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_word | input | DATA_W | Shared transmit data port |
| tx_sync | input | 1 | Pair position marker for the word on the port |
| cfg_dual | input | 1 | 1 = interleaved I/Q, 0 = single channel |
| cfg_q_first | input | 1 | 1 = the opening word of a pair is Q |
| cfg_sync_inv | input | 1 | Sync level that marks an opening word |
| cfg_twos | input | 1 | 1 = input already two's complement |
| cfg_fall | input | 1 | 1 = capture on the falling edge |
| cfg_both | input | 1 | 1 = capture on both edges (dual mode only) |
| i_out | output | DATA_W | I word, signed |
| q_out | output | DATA_W | Q word, signed |
| out_valid | output | 1 | One-cycle strobe for a new output |

## Verification
The bench builds the block with the default width of 14 bits. This makes the offset-to-signed flip at bit 13 visible with full-scale codes such as 0x0000, 0x1FFF, 0x2000 and 0x3FFF. Every capture plan runs in both modes with a sync stream that starts on a stray closing word and contains a doubled opening word. This exercises pair boundaries that cross a clock period in two-edge capture. Each control bit is flipped on its own against a reference sequence, so a lost or swapped control shows up as a mismatched word or a missing strobe.

// File: rtl/txq_pkg.sv
// Package txq_pkg
// Shared constants for the transmit deinterleaver. The block carries two
// capture lanes per rising edge: the earlier word and the later word.
package txq_pkg;
    localparam int TXQ_LANES = 2;

    // Lane index in time order inside one rising-edge period
    typedef enum int {
        LANE_EARLY = 0,
        LANE_LATE  = 1
    } txq_lane_e;
endpackage

// File: rtl/txq_edge_capture.sv
// Module txq_edge_capture
// Registers the shared data port and its sync marker on both clock edges.
// Assumes: reset is synchronous to the edge that samples it; each capture
// register carries a valid flag that becomes set at the first edge that
// sees reset released, so stale power-up contents are never consumed.
module txq_edge_capture #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              tx_sync,
    output logic [DATA_W-1:0] rise_word,
    output logic              rise_sync,
    output logic              rise_vld,
    output logic [DATA_W-1:0] fall_word,
    output logic              fall_sync,
    output logic              fall_vld
);

    // Rising-edge sample of the port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_word <= '0;
            rise_sync <= 1'b0;
            rise_vld  <= 1'b0;
        end else begin
            rise_word <= tx_word;
            rise_sync <= tx_sync;
            rise_vld  <= 1'b1;
        end
    end

    // Falling-edge sample of the port
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            fall_word <= '0;
            fall_sync <= 1'b0;
            fall_vld  <= 1'b0;
        end else begin
            fall_word <= tx_word;
            fall_sync <= tx_sync;
            fall_vld  <= 1'b1;
        end
    end

endmodule

// File: rtl/txq_fmt.sv
// Module txq_fmt
// Turns one captured word into two's complement form. Offset binary input
// has its top bit inverted; two's complement input passes unchanged.
// Assumes: purely combinational, one instance per lane.
module txq_fmt #(
    parameter int DATA_W = 14
) (
    input  logic              is_twos,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] signed_word
);

    localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

    // Offset-to-signed conversion by flipping the sign position
    always_comb begin
        signed_word = is_twos ? raw : (raw ^ MSB_MASK);
    end

endmodule

// File: rtl/txq_pair_asm.sv
// Module txq_pair_asm
// Assembles I/Q pairs from up to LANES time-ordered words per rising edge
// and registers the result. In single-channel mode lane 0 goes straight to
// the I output. Assumes: control inputs change only under reset; at most
// one pair can complete per cycle with two lanes, because completing a
// pair empties the holding slot.
module txq_pair_asm #(
    parameter int DATA_W = 14,
    parameter int LANES  = txq_pkg::TXQ_LANES
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         dual,
    input  logic                         q_first,
    input  logic                         sync_inv,
    input  logic [LANES-1:0]             lane_vld,
    input  logic [LANES-1:0]             lane_sync,
    input  logic [LANES-1:0][DATA_W-1:0] lane_word,
    output logic [DATA_W-1:0]            i_out,
    output logic [DATA_W-1:0]            q_out,
    output logic                         out_valid
);

    logic              hold_v;
    logic [DATA_W-1:0] hold_w;
    logic              nxt_hold_v;
    logic [DATA_W-1:0] nxt_hold_w;
    logic              emit;
    logic [DATA_W-1:0] opener;
    logic [DATA_W-1:0] closer;
    logic              single_go;

    // Walk the lanes in time order, opening, replacing or closing a pair
    always_comb begin
        nxt_hold_v = hold_v;
        nxt_hold_w = hold_w;
        emit       = 1'b0;
        opener     = '0;
        closer     = '0;
        for (int k = 0; k < LANES; k++) begin
            if (lane_vld[k]) begin
                if (lane_sync[k] == sync_inv) begin
                    nxt_hold_v = 1'b1;
                    nxt_hold_w = lane_word[k];
                end else if (nxt_hold_v) begin
                    emit       = 1'b1;
                    opener     = nxt_hold_w;
                    closer     = lane_word[k];
                    nxt_hold_v = 1'b0;
                end
            end
        end
        if (!dual) begin
            nxt_hold_v = 1'b0;
            emit       = 1'b0;
        end
    end

    // Single-channel words bypass pairing
    always_comb begin
        single_go = !dual && lane_vld[txq_pkg::LANE_EARLY];
    end

    // Holding slot and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v    <= 1'b0;
            hold_w    <= '0;
            i_out     <= '0;
            q_out     <= '0;
            out_valid <= 1'b0;
        end else begin
            hold_v    <= nxt_hold_v;
            hold_w    <= nxt_hold_w;
            out_valid <= single_go || emit;
            if (single_go) begin
                i_out <= lane_word[txq_pkg::LANE_EARLY];
                q_out <= '0;
            end else if (emit) begin
                i_out <= q_first ? closer : opener;
                q_out <= q_first ? opener : closer;
            end
        end
    end

    // R2: a single-channel word leaves with a strobe and a zero Q word
    p_single_q_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        single_go |=> (out_valid && q_out == '0));

    // R3: in dual mode, a cycle without a completed pair leaves outputs held
    p_hold_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dual && !emit) |=> (!out_valid && $stable(i_out) && $stable(q_out)));

endmodule

// File: rtl/txq_deinterleave.sv
// Module txq_deinterleave (top)
// Captures words from a shared transmit port on the chosen clock edge(s),
// converts them to signed form and splits them into I and Q outputs.
// Assumes: cfg_* inputs are static and change only while rst_n is low;
// two-edge capture applies only in dual mode.
module txq_deinterleave #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              tx_sync,
    input  logic              cfg_dual,
    input  logic              cfg_q_first,
    input  logic              cfg_sync_inv,
    input  logic              cfg_twos,
    input  logic              cfg_fall,
    input  logic              cfg_both,
    output logic [DATA_W-1:0] i_out,
    output logic [DATA_W-1:0] q_out,
    output logic              out_valid
);

    localparam int LANES = txq_pkg::TXQ_LANES;
    localparam int EARLY = txq_pkg::LANE_EARLY;
    localparam int LATE  = txq_pkg::LANE_LATE;

    logic [DATA_W-1:0]            rise_word;
    logic                         rise_sync;
    logic                         rise_vld;
    logic [DATA_W-1:0]            fall_word;
    logic                         fall_sync;
    logic                         fall_vld;
    logic                         both_act;
    logic [LANES-1:0]             lane_vld;
    logic [LANES-1:0]             lane_sync;
    logic [LANES-1:0][DATA_W-1:0] lane_raw;
    logic [LANES-1:0][DATA_W-1:0] lane_fmt;

    txq_edge_capture #(.DATA_W(DATA_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_word   (tx_word),
        .tx_sync   (tx_sync),
        .rise_word (rise_word),
        .rise_sync (rise_sync),
        .rise_vld  (rise_vld),
        .fall_word (fall_word),
        .fall_sync (fall_sync),
        .fall_vld  (fall_vld)
    );

    // Map capture registers to time-ordered lanes for the active capture plan
    always_comb begin
        both_act = cfg_dual && cfg_both;
        if (both_act || !cfg_fall) begin
            lane_raw[EARLY]  = rise_word;
            lane_sync[EARLY] = rise_sync;
            lane_vld[EARLY]  = rise_vld;
        end else begin
            lane_raw[EARLY]  = fall_word;
            lane_sync[EARLY] = fall_sync;
            lane_vld[EARLY]  = fall_vld;
        end
        lane_raw[LATE]  = fall_word;
        lane_sync[LATE] = fall_sync;
        lane_vld[LATE]  = fall_vld && both_act;
    end

    // One format converter per lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane_fmt
        txq_fmt #(.DATA_W(DATA_W)) u_fmt (
            .is_twos     (cfg_twos),
            .raw         (lane_raw[g]),
            .signed_word (lane_fmt[g])
        );
    end

    txq_pair_asm #(.DATA_W(DATA_W), .LANES(LANES)) u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .dual      (cfg_dual),
        .q_first   (cfg_q_first),
        .sync_inv  (cfg_sync_inv),
        .lane_vld  (lane_vld),
        .lane_sync (lane_sync),
        .lane_word (lane_fmt),
        .i_out     (i_out),
        .q_out     (q_out),
        .out_valid (out_valid)
    );

    // R1: reset clears the outputs by the following edge
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && i_out == '0 && q_out == '0));

    // R9: one word per cycle cannot complete pairs on back-to-back cycles
    p_no_back_to_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dual && !cfg_both && out_valid) |=> !out_valid);

    // R2: single-channel rising capture yields a word every cycle
    p_word_per_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dual && !cfg_fall && rise_vld) |=> out_valid);

endmodule

// File: tb/test_txq_deinterleave.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task predicts each output from the
// requirements and queues it; the monitor pops and compares on strobes.
module test_txq_deinterleave;
    localparam int W = 14;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] din = '0;
    logic         sync = 1'b0;
    logic         cfg_dual = 0, cfg_q_first = 0, cfg_sync_inv = 0;
    logic         cfg_twos = 0, cfg_fall = 0, cfg_both = 0;
    logic [W-1:0] i_out, q_out;
    logic         out_valid;

    int n_chk = 0;
    int n_fail = 0;
    bit mon_en = 0;
    bit m_pv = 0;
    logic [W-1:0] m_pd = '0;
    logic [2*W-1:0] exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    txq_deinterleave #(.DATA_W(W)) i_txq_deinterleave (
        .clk(clk), .rst_n(rst_n), .tx_word(din), .tx_sync(sync),
        .cfg_dual(cfg_dual), .cfg_q_first(cfg_q_first),
        .cfg_sync_inv(cfg_sync_inv), .cfg_twos(cfg_twos),
        .cfg_fall(cfg_fall), .cfg_both(cfg_both),
        .i_out(i_out), .q_out(q_out), .out_valid(out_valid)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] conv(input logic [W-1:0] d);
        return cfg_twos ? d : {~d[W-1], d[W-2:0]};
    endfunction

    // Reference prediction per captured word
    task automatic predict(input logic [W-1:0] d, input logic s, input string tag);
        if (!cfg_dual) begin
            exp_q.push_back({conv(d), {W{1'b0}}});
            tag_q.push_back(tag);
        end else if (s == cfg_sync_inv) begin
            m_pv = 1;
            m_pd = conv(d);
        end else if (m_pv) begin
            m_pv = 0;
            exp_q.push_back(cfg_q_first ? {conv(d), m_pd} : {m_pd, conv(d)});
            tag_q.push_back(tag);
        end
    endtask

    // Drive one word ahead of its capture edge (falling or rising)
    task automatic put(input logic [W-1:0] d, input logic s, input bit at_fall,
                       input string tag);
        if (at_fall) begin @(posedge clk); #1; end
        else begin @(negedge clk); #1; end
        din = d;
        sync = s;
        rst_n = 1'b1;
        predict(d, s, tag);
    endtask

    task automatic run_start(input bit dual, input bit qf, input bit sinv,
                             input bit twos, input bit fall, input bit both);
        rst_n = 1'b0;
        cfg_dual = dual; cfg_q_first = qf; cfg_sync_inv = sinv;
        cfg_twos = twos; cfg_fall = fall; cfg_both = both;
        m_pv = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!out_valid && i_out == '0 && q_out == '0, "R1 reset state",
            {i_out, q_out}, '0);
        mon_en = 1;
    endtask

    task automatic run_end(input bit last_fall, input string tag);
        if (!last_fall) @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        #1;
        mon_en = 0;
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
        rst_n = 1'b0;
    endtask

    // Monitor: compare every strobe against the queue
    always @(negedge clk) begin
        if (mon_en && rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R9 unexpected strobe", {i_out, q_out}, '0);
            end else begin
                logic [2*W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({i_out, q_out} == e, t, {i_out, q_out}, e);
            end
        end
    end

    // Dual-mode stream: stray closer, doubled opener, then pairs
    task automatic dual_stream(input bit fl, input bit sinv, input string tag);
        put(14'h0AAA, ~sinv, fl, tag);
        put(14'h0111, sinv, fl, tag);
        put(14'h0222, sinv, fl, tag);
        put(14'h3FFF, ~sinv, fl, tag);
        put(14'h2000, sinv, fl, tag);
        put(14'h1FFF, ~sinv, fl, tag);
        put(14'h0000, sinv, fl, tag);
        put(14'h1234, ~sinv, fl, tag);
    endtask

    initial begin
        // R2, R6 offset binary, rising capture, single channel
        run_start(0, 0, 0, 0, 0, 0);
        put(14'h0000, 0, 0, "R2 R6 offset");
        put(14'h1FFF, 1, 0, "R2 R6 offset");
        put(14'h2000, 0, 0, "R2 R6 offset");
        put(14'h3FFF, 0, 0, "R2 R6 offset");
        put(14'h0123, 1, 0, "R2 R6 offset");
        run_end(0, "R2 drained");
        // R6 two's complement passthrough
        run_start(0, 0, 0, 1, 0, 0);
        put(14'h2000, 0, 0, "R6 twos");
        put(14'h1FFF, 0, 0, "R6 twos");
        put(14'h3ABC, 1, 0, "R6 twos");
        run_end(0, "R6 drained");
        // R7 falling capture, single channel
        run_start(0, 0, 0, 0, 1, 0);
        put(14'h0101, 0, 1, "R7 falling single");
        put(14'h2345, 0, 1, "R7 falling single");
        put(14'h3F00, 1, 1, "R7 falling single");
        run_end(1, "R7 single drained");
        // R10 two-edge bit ignored in single mode
        run_start(0, 0, 0, 0, 0, 1);
        put(14'h0F0F, 0, 0, "R10 both ignored");
        put(14'h3030, 1, 0, "R10 both ignored");
        put(14'h1111, 0, 0, "R10 both ignored");
        run_end(0, "R10 drained");
        // R3 R5 R9 dual, I first, sync low opens
        run_start(1, 0, 0, 0, 0, 0);
        dual_stream(0, 0, "R3 R5 R9 dual i-first");
        run_end(0, "R3 drained");
        // R4 Q first
        run_start(1, 1, 0, 0, 0, 0);
        dual_stream(0, 0, "R4 dual q-first");
        run_end(0, "R4 drained");
        // R5 inverted sync, two's complement input
        run_start(1, 0, 1, 1, 0, 0);
        dual_stream(0, 1, "R5 inverted sync");
        run_end(0, "R5 drained");
        // R7 dual with falling capture
        run_start(1, 0, 0, 0, 1, 0);
        dual_stream(1, 0, "R7 falling dual");
        run_end(1, "R7 dual drained");
        // R8 both edges, pairs aligned to rising then falling
        run_start(1, 0, 0, 0, 0, 1);
        for (int k = 0; k < 4; k++) begin
            put(14'(16'h0100 * k + 1), 0, 0, "R8 two-edge aligned");
            put(14'(16'h0100 * k + 2), 1, 1, "R8 two-edge aligned");
        end
        run_end(1, "R8 aligned drained");
        // R8 R9 both edges, pairs straddling a rising edge, cfg_fall set
        run_start(1, 1, 0, 0, 1, 1);
        put(14'h0AAA, 1, 0, "R8 R9 two-edge straddle");
        put(14'h0111, 0, 1, "R8 R9 two-edge straddle");
        put(14'h2222, 1, 0, "R8 R9 two-edge straddle");
        put(14'h0333, 0, 1, "R8 R9 two-edge straddle");
        put(14'h0444, 0, 0, "R8 R9 two-edge straddle");
        put(14'h3555, 1, 1, "R8 R9 two-edge straddle");
        run_end(1, "R8 straddle drained");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(5.0 * 150000);
        chk(0, "watchdog expired", '0, '0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule